// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a single-clock synchronous static RAM that serves as the secondary cache beside a processor. Each word is 32 bits wide, split into four byte lanes. The depth is set by an address-width parameter. Address, write data and every control input except output enable, sleep and burst-order select are sampled on the rising clock edge. Read data is registered, so it appears on the output one cycle after the edge that performs the read.

An access starts from one of two address strobes. The processor strobe always begins a read. The cache-controller strobe begins either a read or a write, as the write controls decide. After a start, the block makes the next addresses of a four-beat burst itself. The advance input either steps to the next beat or holds the current beat as a wait state. The low two address bits follow a linear or an interleaved order, chosen by a static mode input. Three chip enables qualify each start. A sleep input stops all access while it is high and for a fixed wake-up period after it falls. The output bus is modelled as a data word plus a drive flag, and the flag stands for the bus being out of high impedance. The read path is a plain pin-level interface with no back-pressure: an output that is not driven simply carries no data, and the design holds no data waiting to be taken.

Top module: `burst_sram`

## Requirements
- R1: A read performed at a rising edge presents the addressed word on `rdata` with `rdata_drv` high from that edge until the next one, provided `oe_n` is low and the block is awake.
- R2: With `bwe_n` low and `gw_n` high, byte strobe `bstrb_n[0]` writes bits 7:0, `bstrb_n[1]` bits 15:8, `bstrb_n[2]` bits 23:16 and `bstrb_n[3]` bits 31:24. A strobe that is low has no effect while `bwe_n` is high.
- R3: `gw_n` low writes all four bytes, whatever the levels of `bwe_n` and `bstrb_n`.
- R4: A cycle is a write when `gw_n` is low, or when `bwe_n` is low with at least one `bstrb_n` bit low. Otherwise it is a read.
- R5: An edge with `cpu_stb_n` low starts a read at `addr` even when the write controls request a write, and memory is left unchanged. A write to that address can follow at the next edge with both strobes high and `adv_n` high.
- R6: An edge with `cpu_stb_n` high and `ctl_stb_n` low starts an access at `addr`. If the write decode is true, that edge writes `wdata`.
- R7: At an edge with both strobes high during a burst, `adv_n` low steps a 2-bit beat count. With `lin_mode` = 1 the low address bits are (start + count) mod 4. With `lin_mode` = 0 they are start XOR count. Upper address bits keep the start value.
- R8: At an edge with both strobes high during a burst, `adv_n` high repeats the current address, for a read or a write.
- R9: A start is selected only with `ce_n` = 0, `ce2` = 1 and `ce3_n` = 0. A start edge that is not selected performs no access, ends the burst and leaves the output undriven.
- R10: While `sleep` is high, and at the first three edges after it falls, nothing is read or written, the burst ends and the output is undriven. Stored words are kept. The fourth edge after the fall accepts an access.
- R11: `rdata_drv` is high only while `oe_n` is low. When it is low, `rdata` is zero.
- R12: After reset no burst is active and the output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address sampled at a start |
| wdata | input | 32 | Write data |
| cpu_stb_n | input | 1 | Processor address strobe, active low, always a read |
| ctl_stb_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, low steps and high holds |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| gw_n | input | 1 | Global write of all bytes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bstrb_n | input | 4 | Byte write strobes, active low, one per lane |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Power-down request, active high |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_drv | output | 1 | High when the data bus is driven |

## Verification
The assertions assume that `lin_mode` does not change while a burst is running. This matters because the hold check compares each repeated address with the one before it. They also assume that reset is applied before the first access. The stimulus changes `lin_mode` only before a new start strobe, and it holds reset low for several edges at time zero. Apart from that the stimulus is free to drive any mix of strobes, write controls, enables, `oe_n` and `sleep`, and it drives all inputs half a cycle away from the sampling edge.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

  localparam int LANE_W = 8;

  // What the strobes and enables ask for at an edge
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_CPU   = 2'd1,
    K_CTL   = 2'd2,
    K_DESEL = 2'd3
  } start_kind_t;

  // Low address bits of a beat within a four-beat burst
  function automatic logic [1:0] beat_lsb(input logic [1:0] first,
                                          input logic [1:0] count,
                                          input logic       linear);
    logic [1:0] r;
    if (linear) r = first + count;
    else        r = first ^ count;
    return r;
  endfunction

endpackage

// File: rtl/bsram_wake.sv
`timescale 1ns/1ps
module bsram_wake #(
  parameter int WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic awake
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_INIT = CW'(WAKE_CYC);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hold_cnt <= '0;
    else if (sleep)           hold_cnt <= WAKE_INIT;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
  end

  assign awake = !sleep && (hold_cnt == '0);
endmodule

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awake,
  input  logic [AW-1:0] addr,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          adv_n,
  input  logic          ce_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bstrb_n,
  input  logic          lin_mode,
  output logic          acc_en,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_ben
);
  localparam int HI_W = AW - 2;

  logic          selected;
  logic          wr_req;
  start_kind_t   kind;
  logic          is_start;
  logic          active;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    n_cnt;
  logic [AW-1:0] use_base;

  assign selected = !ce_n && ce2 && !ce3_n;
  assign wr_req   = !gw_n || (!bwe_n && !(&bstrb_n));

  always_comb begin
    if (!gw_n)       acc_ben = '1;
    else if (!bwe_n) acc_ben = ~bstrb_n;
    else             acc_ben = '0;
  end

  always_comb begin
    if (!cpu_stb_n)      kind = selected ? K_CPU : K_DESEL;
    else if (!ctl_stb_n) kind = selected ? K_CTL : K_DESEL;
    else                 kind = K_NONE;
  end

  assign is_start = (kind == K_CPU) || (kind == K_CTL);

  always_comb begin
    if (is_start)    n_cnt = 2'd0;
    else if (!adv_n) n_cnt = cnt + 2'd1;
    else             n_cnt = cnt;
  end

  assign use_base = is_start ? addr : base;
  assign acc_addr = {use_base[AW-1 -: HI_W], beat_lsb(use_base[1:0], n_cnt, lin_mode)};
  assign acc_en   = awake && (is_start || ((kind == K_NONE) && active));
  assign acc_wr   = acc_en && (kind != K_CPU) && wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (!awake) begin
      active <= 1'b0;
    end else begin
      unique case (kind)
        K_CPU, K_CTL: begin
          active <= 1'b1;
          base   <= addr;
          cnt    <= 2'd0;
        end
        K_DESEL: active <= 1'b0;
        default: if (active) cnt <= n_cnt;
      endcase
    end
  end
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array
  import bsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [AW-1:0]      acc_addr,
  input  logic [NB-1:0]      acc_ben,
  input  logic [NB*LANE_W-1:0] wdata,
  output logic [NB*LANE_W-1:0] rd_data,
  output logic               rd_vld
);
  localparam int DEPTH = 1 << AW;

  logic do_read;
  assign do_read = acc_en && !acc_wr;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LANE_W-1:0] lane [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (acc_en && acc_wr && acc_ben[b])
        lane[acc_addr] <= wdata[b*LANE_W +: LANE_W];
      if (do_read)
        lane_q <= lane[acc_addr];
    end

    assign rd_data[b*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= do_read;
  end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WAKE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bstrb_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              lin_mode,
  output logic [31:0]       rdata,
  output logic              rdata_drv
);
  localparam int NB = 4;

  logic              awake;
  logic              acc_en;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [NB-1:0]     acc_ben;
  logic [31:0]       rd_data;
  logic              rd_vld;

  bsram_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .awake(awake)
  );

  bsram_ctrl #(.AW(ADDR_W), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .awake(awake), .addr(addr),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bstrb_n(bstrb_n), .lin_mode(lin_mode),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_ben(acc_ben)
  );

  bsram_array #(.AW(ADDR_W), .NB(NB)) u_array (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_ben(acc_ben), .wdata(wdata),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  assign rdata_drv = rd_vld && !oe_n && awake;
  assign rdata     = rdata_drv ? rd_data : '0;
endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_stb_n,
  input logic          ctl_stb_n,
  input logic          adv_n,
  input logic          ce_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          oe_n,
  input logic          sleep,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [AW-1:0] acc_addr,
  input logic          rdata_drv
);
  // R11
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drv |-> !oe_n);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rdata_drv && !acc_en));

  // R9
  desel_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cpu_stb_n || !ctl_stb_n) && !(!ce_n && ce2 && !ce3_n)) |=> !rdata_drv);

  // R5
  cpu_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stb_n |-> !acc_wr);

  // R1
  drive_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drv |-> $past(acc_en && !acc_wr));

  // R8
  hold_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en) && acc_en && cpu_stb_n && ctl_stb_n && adv_n) |-> $stable(acc_addr));
endmodule

bind burst_sram bsram_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
  .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
  .sleep(sleep), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .rdata_drv(rdata_drv)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          cpu_stb_n, ctl_stb_n, adv_n, ce_n, ce2, ce3_n;
  logic          gw_n, bwe_n, oe_n, sleep, lin_mode;
  logic [3:0]    bstrb_n;
  logic [31:0]   rdata;
  logic          rdata_drv;

  burst_sram #(.ADDR_W(AW), .WAKE_CYC(3)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bstrb_n(bstrb_n), .oe_n(oe_n), .sleep(sleep), .lin_mode(lin_mode),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R12";

  // Reference model state
  logic [31:0] mmem [int];
  bit          m_active;
  int          m_base, m_cnt, m_wake;
  bit          m_vld, m_qk;
  logic [31:0] m_q;

  function automatic int beat_addr(int b, int c, bit lin);
    int lo;
    lo = lin ? ((b + c) % 4) : ((b % 4) ^ c);
    return (b & ~3) | lo;
  endfunction

  task automatic do_access(int a);
    bit wr;
    logic [31:0] w;
    wr = (gw_n == 1'b0) || (bwe_n == 1'b0 && bstrb_n != 4'hF);
    if (wr) begin
      w = mmem.exists(a) ? mmem[a] : 32'h0;
      for (int b = 0; b < 4; b++)
        if (gw_n == 1'b0 || bstrb_n[b] == 1'b0) w[b*8 +: 8] = wdata[b*8 +: 8];
      mmem[a] = w;
      m_vld = 0;
    end else begin
      m_vld = 1;
      m_qk  = mmem.exists(a);
      m_q   = m_qk ? mmem[a] : 32'h0;
    end
  endtask

  task automatic model_edge();
    bit sel;
    if (!rst_n) begin
      m_active = 0; m_vld = 0; m_wake = 0; m_cnt = 0; m_base = 0;
    end else if (sleep) begin
      m_wake = 3; m_active = 0; m_vld = 0;
    end else if (m_wake > 0) begin
      m_wake--; m_vld = 0;
    end else begin
      sel = (ce_n == 0) && (ce2 == 1) && (ce3_n == 0);
      if (cpu_stb_n == 0 || ctl_stb_n == 0) begin
        if (!sel) begin
          m_active = 0; m_vld = 0;
        end else begin
          m_active = 1; m_base = int'(addr); m_cnt = 0;
          if (cpu_stb_n == 0) begin
            m_vld = 1; m_qk = mmem.exists(m_base);
            m_q = m_qk ? mmem[m_base] : 32'h0;
          end else do_access(m_base);
        end
      end else if (m_active) begin
        if (adv_n == 0) m_cnt = (m_cnt + 1) % 4;
        do_access(beat_addr(m_base, m_cnt, lin_mode));
      end else m_vld = 0;
    end
  endtask

  task automatic compare();
    bit exp_drv;
    exp_drv = m_vld && !oe_n && !sleep && (m_wake == 0);
    n_tests++;
    if (rdata_drv !== exp_drv) begin
      n_fail++;
      $display("FAIL %s: rdata_drv actual %0b expected %0b at %0t", cur_req, rdata_drv, exp_drv, $time);
    end else if (exp_drv && m_qk && rdata !== m_q) begin
      n_fail++;
      $display("FAIL %s: rdata actual %08h expected %08h at %0t", cur_req, rdata, m_q, $time);
    end else if (!exp_drv && rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL %s: undriven rdata actual %08h expected 00000000 at %0t", cur_req, rdata, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
    bstrb_n = 4'hF; ce_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  task automatic ctl_start(int a, logic [31:0] d, logic g, logic be, logic [3:0] bs);
    quiet(); ctl_stb_n = 0; addr = AW'(a); wdata = d; gw_n = g; bwe_n = be; bstrb_n = bs;
    cyc();
  endtask

  task automatic cpu_start(int a);
    quiet(); cpu_stb_n = 0; addr = AW'(a);
    cyc();
  endtask

  task automatic beat(logic adv, logic g, logic [31:0] d);
    quiet(); adv_n = adv; gw_n = g; wdata = d;
    cyc();
  endtask

  initial begin
    rst_n = 0; addr = '0; wdata = '0; oe_n = 0; sleep = 0; lin_mode = 1;
    quiet();
    repeat (3) cyc();
    rst_n = 1;
    cur_req = "R12"; quiet(); cyc(); cyc();

    // R3 R6: global write from the controller strobe, then read back (R1)
    cur_req = "R3";
    ctl_start(8'h10, 32'hA1B2C3D4, 0, 1, 4'hF);
    ctl_start(8'h11, 32'h11223344, 0, 0, 4'b0000);
    cur_req = "R1";
    cpu_start(8'h10); quiet(); cyc();
    cpu_start(8'h11); cyc();

    // R2: byte lanes 0 and 2 only
    cur_req = "R2";
    ctl_start(8'h11, 32'hEEDDCCBB, 1, 0, 4'b1010);
    cpu_start(8'h11); quiet(); cyc();
    // R2: strobes with bwe_n high are a read (R4)
    cur_req = "R4";
    ctl_start(8'h11, 32'h99999999, 1, 1, 4'b0000);
    cpu_start(8'h11);
    ctl_start(8'h11, 32'h5A5A5A5A, 1, 0, 4'b0111);
    cpu_start(8'h11); quiet(); cyc();

    // R5: processor strobe with write asserted is a read, write follows
    cur_req = "R5";
    quiet(); cpu_stb_n = 0; addr = 8'h10; gw_n = 0; wdata = 32'hDEADBEEF; cyc();
    beat(1, 0, 32'h0BADF00D);
    cpu_start(8'h10); quiet(); cyc();

    // R7: linear write burst from 0x22, then read burst
    cur_req = "R7"; lin_mode = 1;
    ctl_start(8'h22, 32'h00000022, 0, 1, 4'hF);
    for (int i = 1; i < 4; i++) beat(0, 0, 32'h100 + i);
    cpu_start(8'h21);
    for (int i = 0; i < 4; i++) beat(0, 1, 0);
    // R7: interleaved
    lin_mode = 0;
    ctl_start(8'h41, 32'h00000041, 0, 1, 4'hF);
    for (int i = 1; i < 4; i++) beat(0, 0, 32'h200 + i);
    cpu_start(8'h43);
    for (int i = 0; i < 4; i++) beat(0, 1, 0);
    for (int a = 8'h40; a < 8'h44; a++) cpu_start(a);
    lin_mode = 1;
    for (int a = 8'h20; a < 8'h24; a++) cpu_start(a);

    // R8: suspend reads and a suspended write
    cur_req = "R8";
    cpu_start(8'h22);
    beat(1, 1, 0); beat(1, 1, 0); beat(0, 1, 0); beat(1, 1, 0);
    beat(1, 0, 32'hCAFE0023); beat(1, 1, 0);

    // R9: deselected starts
    cur_req = "R9";
    cpu_start(8'h22);
    quiet(); cpu_stb_n = 0; addr = 8'h10; ce2 = 0; cyc();
    beat(0, 1, 0); beat(0, 0, 32'hFFFFFFFF);
    quiet(); ctl_stb_n = 0; addr = 8'h10; ce3_n = 1; gw_n = 0; wdata = 32'h12121212; cyc();
    quiet(); ctl_stb_n = 0; addr = 8'h10; ce_n = 1; gw_n = 0; wdata = 32'h34343434; cyc();
    cpu_start(8'h10); quiet(); cyc();

    // R11: output enable gating, asynchronous
    cur_req = "R11";
    cpu_start(8'h11);
    oe_n = 1; #1; compare();
    beat(1, 1, 0);
    oe_n = 0; #1; compare();
    beat(1, 1, 0);

    // R10: sleep and wake-up
    cur_req = "R10";
    ctl_start(8'h30, 32'h30303030, 0, 1, 4'hF);
    cpu_start(8'h30);
    sleep = 1; #1; compare();
    ctl_start(8'h30, 32'hBAD0BAD0, 0, 1, 4'hF);
    ctl_start(8'h30, 32'hBAD1BAD1, 0, 1, 4'hF);
    sleep = 0;
    for (int i = 0; i < 3; i++) begin
      quiet(); cpu_stb_n = 0; addr = 8'h30; cyc();
      ctl_start(8'h30, 32'hBAD2BAD2, 0, 1, 4'hF);
      i++;
      if (i >= 3) break;
      i--;
      break;
    end
    ctl_start(8'h30, 32'hBAD3BAD3, 0, 1, 4'hF);
    ctl_start(8'h31, 32'h31313131, 0, 1, 4'hF);
    cpu_start(8'h30); cpu_start(8'h31); quiet(); cyc();

    // R12: reset mid-burst
    cur_req = "R12";
    cpu_start(8'h31);
    rst_n = 0; #1; cyc();
    rst_n = 1; beat(0, 1, 0); beat(1, 1, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule